// File: doc/BRIEF.md
# Burst Length and Quality Supervisor

This block is the control state machine that decides when a received data burst is over. It waits in an acquisition state until a preamble detection strobe arrives, then moves to a tracking state. While tracking it counts the data symbols reported by a per-symbol strobe. Alongside that count it counts how many of those symbols were flagged as weak, meaning their estimated power stayed at or under the data threshold.

A burst ends in one of three ways. The length check fires on the last programmed data symbol. The quality check fires on the first weak symbol after the weak count has already reached its programmed limit. A manual abort input ends the burst at once. Either automatic check can be switched off with its own disable input. Every return to acquisition gives a one-cycle end-of-burst pulse and a cause code. Symbol detection and the power comparison happen upstream and arrive here only as strobes.

Top module: `burst_supervisor`

## Requirements
- R1: After a synchronous reset, `tracking`, `eob` and `eob_cause` are all zero.
- R2: A clock edge with `acq_det` high while in acquisition enters tracking, with both the symbol count and the weak-symbol count at zero. `acq_det` while tracking is ignored and does not restart the counts.
- R3: With `len_off` low, the burst ends on the `sym_strb` that brings the number of processed symbols to `len_cfg` minus 2. `len_cfg` must be in the range 3 to 65535. After that edge `tracking` is 0, `eob` is 1 and `eob_cause` is 2'b01.
- R4: With `qual_off` low, a strobe with `sym_miss` high ends the burst only if the weak count had already reached `miss_lim` before it. The burst therefore ends on weak symbol number `miss_lim`+1 and gives `eob_cause` 2'b10.
- R5: With `qual_off` high, weak symbols never end a burst.
- R6: With `len_off` high, the symbol count never ends a burst, so tracking continues until abort or a quality end.
- R7: `abort` high while tracking ends the burst at that edge with `eob_cause` 2'b11. This takes precedence over a symbol strobe in the same cycle that would end the burst for length or quality.
- R8: `abort` high while in acquisition gives no `eob` and blocks a simultaneous `acq_det`, so the block stays in acquisition.
- R9: `eob` is high for exactly one cycle per burst end, and `eob_cause` is 2'b00 whenever `eob` is low.
- R10: When the length and quality conditions fall on the same strobe, the cause reported is quality (2'b10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_det | input | 1 | Preamble detected strobe |
| sym_strb | input | 1 | One data symbol processed |
| sym_miss | input | 1 | Qualifies `sym_strb`: symbol power under threshold |
| abort | input | 1 | Manual end of burst |
| len_cfg | input | LEN_W (16) | Symbols-per-burst setting; burst holds value minus 2 |
| miss_lim | input | MISS_W (4) | Weak-symbol limit |
| len_off | input | 1 | Disable length termination |
| qual_off | input | 1 | Disable quality termination |
| tracking | output | 1 | High while a burst is being tracked |
| eob | output | 1 | One-cycle end-of-burst pulse |
| eob_cause | output | 2 | 01 length, 10 quality, 11 abort, 00 otherwise |

## Verification
The assertions assume that `len_cfg` is at least 3 whenever length termination is enabled during tracking. They also assume that `miss_lim` and `len_cfg` do not change while a burst is being tracked, since the weak-count bound depends on a stable limit. The stimulus loads the configuration only while the block is in acquisition, one cycle or more before `acq_det`, and uses only legal lengths. `sym_miss` is meaningful only together with `sym_strb`, and the stimulus drives it only on strobe cycles.

// File: rtl/bsup_pkg.sv
package bsup_pkg;
  typedef enum logic [1:0] {
    END_NONE  = 2'b00,
    END_LEN   = 2'b01,
    END_QUAL  = 2'b10,
    END_ABORT = 2'b11
  } end_cause_t;
endpackage

// File: rtl/bsup_len_ctr.sv
module bsup_len_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] limit_cfg,
  output logic          last
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW:0]   ONE  = {{CW{1'b0}}, 1'b1};
  localparam logic [CW:0]   TWO  = {{(CW-1){1'b0}}, 2'b10};

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_nxt;
  logic [CW:0]   target;

  assign cnt_nxt = {1'b0, cnt_q} + ONE;
  assign target  = {1'b0, limit_cfg} - TWO;
  assign last    = step && (cnt_nxt == target);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (step && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bsup_miss_ctr.sv
module bsup_miss_ctr #(
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          miss,
  input  logic [MW-1:0] limit,
  output logic          trip
);
  logic [MW-1:0] cnt_q;
  logic          at_lim;

  assign at_lim = (cnt_q == limit);
  assign trip   = miss && at_lim;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (miss && !at_lim) cnt_q <= cnt_q + 1'b1;
  end

  AST_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
    !clr |-> cnt_q <= limit); // R4
endmodule

// File: rtl/burst_supervisor.sv
module burst_supervisor
  import bsup_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_det,
  input  logic              sym_strb,
  input  logic              sym_miss,
  input  logic              abort,
  input  logic [LEN_W-1:0]  len_cfg,
  input  logic [MISS_W-1:0] miss_lim,
  input  logic              len_off,
  input  logic              qual_off,
  output logic              tracking,
  output logic              eob,
  output logic [1:0]        eob_cause
);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(3);

  logic       trk_q, trk_d;
  logic       eob_q, eob_d;
  end_cause_t cause_q, cause_d;
  logic       step, miss, last, trip, clr_cnt;

  assign clr_cnt = !trk_q;
  assign step    = trk_q && sym_strb;
  assign miss    = step && sym_miss;

  bsup_len_ctr #(.CW(LEN_W)) u_len (
    .clk(clk), .rst(rst), .clr(clr_cnt), .step(step),
    .limit_cfg(len_cfg), .last(last)
  );

  bsup_miss_ctr #(.MW(MISS_W)) u_miss (
    .clk(clk), .rst(rst), .clr(clr_cnt), .miss(miss),
    .limit(miss_lim), .trip(trip)
  );

  always_comb begin
    trk_d   = trk_q;
    eob_d   = 1'b0;
    cause_d = END_NONE;
    if (abort) begin
      trk_d = 1'b0;
      if (trk_q) begin
        eob_d   = 1'b1;
        cause_d = END_ABORT;
      end
    end else if (!trk_q) begin
      if (acq_det) trk_d = 1'b1;
    end else if (!qual_off && trip) begin
      trk_d   = 1'b0;
      eob_d   = 1'b1;
      cause_d = END_QUAL;
    end else if (!len_off && last) begin
      trk_d   = 1'b0;
      eob_d   = 1'b1;
      cause_d = END_LEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_q   <= 1'b0;
      eob_q   <= 1'b0;
      cause_q <= END_NONE;
    end else begin
      trk_q   <= trk_d;
      eob_q   <= eob_d;
      cause_q <= cause_d;
    end
  end

  assign tracking  = trk_q;
  assign eob       = eob_q;
  assign eob_cause = cause_q;

  AST_LEN_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (trk_q && !len_off) |-> len_cfg >= LEN_MIN); // R3
  AST_EOB_FROM_TRACK: assert property (@(posedge clk) disable iff (rst)
    eob |-> $past(trk_q)); // R9
  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !eob |-> eob_cause == END_NONE); // R9
  AST_EOB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eob |=> !eob); // R9
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (rst)
    (abort && trk_q) |=> (eob && eob_cause == END_ABORT && !tracking)); // R7
  AST_IDLE_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (abort && !trk_q) |=> (!eob && !tracking)); // R8
  AST_NO_LEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (trk_q && len_off) |=> eob_cause != END_LEN); // R6
  AST_NO_QUAL_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (trk_q && qual_off) |=> eob_cause != END_QUAL); // R5
endmodule

// File: tb/sim_burst_supervisor.sv
module sim_burst_supervisor;
  localparam time CYC = 10ns;
  localparam int  NV  = 10;

  logic        clk = 1'b0;
  logic        rst, acq_det, sym_strb, sym_miss, abort, len_off, qual_off;
  logic [15:0] len_cfg;
  logic [3:0]  miss_lim;
  logic        tracking, eob;
  logic [1:0]  eob_cause;

  int nchk = 0;
  int nfail = 0;

  always #(CYC/2) clk = ~clk;

  burst_supervisor u0 (
    .clk(clk), .rst(rst), .acq_det(acq_det), .sym_strb(sym_strb),
    .sym_miss(sym_miss), .abort(abort), .len_cfg(len_cfg),
    .miss_lim(miss_lim), .len_off(len_off), .qual_off(qual_off),
    .tracking(tracking), .eob(eob), .eob_cause(eob_cause)
  );

  // fields: req(4) len(16) lim(4) len_off qual_off miss_mask(16) end_at(5) cause(2)
  localparam logic [48:0] VEC [NV] = '{
    {4'd3,  16'd5,  4'd3,  1'b0, 1'b0, 16'h0000, 5'd3,  2'b01}, // R3 length 5 -> 3 symbols
    {4'd3,  16'd3,  4'd3,  1'b0, 1'b0, 16'h0000, 5'd1,  2'b01}, // R3 minimum length
    {4'd4,  16'd20, 4'd2,  1'b0, 1'b0, 16'hFFFF, 5'd3,  2'b10}, // R4 third weak symbol ends
    {4'd4,  16'd20, 4'd0,  1'b0, 1'b0, 16'h0010, 5'd5,  2'b10}, // R4 zero limit
    {4'd4,  16'd20, 4'd2,  1'b0, 1'b0, 16'h0505, 5'd9,  2'b10}, // R4 scattered misses
    {4'd5,  16'd12, 4'd1,  1'b0, 1'b1, 16'hFFFF, 5'd10, 2'b01}, // R5 quality off
    {4'd6,  16'd5,  4'd15, 1'b1, 1'b0, 16'h0000, 5'd0,  2'b00}, // R6 length off
    {4'd10, 16'd4,  4'd1,  1'b0, 1'b0, 16'h0003, 5'd2,  2'b10}, // R10 tie -> quality
    {4'd6,  16'd4,  4'd1,  1'b1, 1'b1, 16'hFFFF, 5'd0,  2'b00}, // R6 both off
    {4'd3,  16'd10, 4'd2,  1'b0, 1'b0, 16'h00C0, 5'd8,  2'b01}  // R3 misses under limit
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    acq_det = 0; sym_strb = 0; sym_miss = 0; abort = 0;
  endtask

  task automatic start_burst();
    acq_det = 1; tick(); acq_det = 0;
  endtask

  initial begin
    #(CYC * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst = 1; idle_in(); len_cfg = 16'd5; miss_lim = 4'd3; len_off = 0; qual_off = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 tracking", 32'(tracking), 0);
    chk("R1 eob", 32'(eob), 0);
    chk("R1 cause", 32'(eob_cause), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [48:0] e;
      string       tag;
      int          done;
      e = VEC[v];
      tag = $sformatf("R%0d vec%0d", e[48:45], v);
      len_cfg = e[44:29]; miss_lim = e[28:25]; len_off = e[24]; qual_off = e[23];
      tick();
      start_burst();
      chk({tag, " R2 enter"}, 32'(tracking), 1);
      done = 0;
      for (int i = 1; i <= 16 && done == 0; i++) begin
        sym_strb = 1; sym_miss = e[6 + i];
        tick();
        sym_strb = 0; sym_miss = 0;
        if (i == int'(e[6:2])) begin
          chk({tag, " eob"}, 32'(eob), 1);
          chk({tag, " cause"}, 32'(eob_cause), 32'(e[1:0]));
          chk({tag, " left"}, 32'(tracking), 0);
          done = 1;
        end else begin
          chk({tag, " no eob"}, 32'(eob), 0);
        end
      end
      if (done == 0) begin
        chk({tag, " still tracking"}, 32'(tracking), 1);
        abort = 1; tick(); abort = 0;
        chk({tag, " R7 abort cause"}, 32'(eob_cause), 3);
      end
      tick();
      chk({tag, " R9 pulse one cycle"}, 32'(eob), 0);
      chk({tag, " R9 cause cleared"}, 32'(eob_cause), 0);
    end

    // R2: acq_det while tracking does not restart counts
    len_cfg = 16'd5; miss_lim = 4'd3; len_off = 0; qual_off = 0;
    tick();
    start_burst();
    sym_strb = 1; tick();
    acq_det = 1; tick(); acq_det = 0;
    sym_strb = 0;
    chk("R2 acq ignored eob", 32'(eob), 0);
    chk("R2 acq ignored still tracking", 32'(tracking), 1);
    sym_strb = 1; tick(); sym_strb = 0;
    chk("R2 ends on third symbol", 32'(eob_cause), 1);
    tick();

    // R7: abort beats a length end in the same cycle
    len_cfg = 16'd3;
    tick();
    start_burst();
    sym_strb = 1; abort = 1; tick(); sym_strb = 0; abort = 0;
    chk("R7 abort priority eob", 32'(eob), 1);
    chk("R7 abort priority cause", 32'(eob_cause), 3);
    chk("R7 left tracking", 32'(tracking), 0);
    tick();

    // R8: abort in acquisition blocks acq_det and gives no eob
    abort = 1; acq_det = 1; tick(); abort = 0; acq_det = 0;
    chk("R8 no eob", 32'(eob), 0);
    chk("R8 stays in acquisition", 32'(tracking), 0);

    // R2: strobes in acquisition have no effect on the next burst
    len_cfg = 16'd5;
    sym_strb = 1; sym_miss = 1; repeat (4) tick(); sym_strb = 0; sym_miss = 0;
    chk("R2 idle strobes no eob", 32'(eob), 0);
    start_burst();
    sym_strb = 1; tick(); tick();
    chk("R2 no early end", 32'(eob), 0);
    tick(); sym_strb = 0;
    chk("R2 counts from zero", 32'(eob_cause), 1);
    tick();

    // R1: reset while tracking returns to reset state
    start_burst();
    rst = 1; tick(); rst = 0;
    chk("R1 reset mid-burst tracking", 32'(tracking), 0);
    chk("R1 reset mid-burst eob", 32'(eob), 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule